// File: doc/BRIEF.md
# Host-Side Memory Access Steering for a Time-Slot Switch

This block sits between a simple parallel host bus and the three internal memories of a time-slot switch: the data memory (switched input bytes), the low connection memory and the high connection memory. It holds one 8-bit mode register. That register chooses which memory the host reaches and which serial stream's 32-channel window is visible. It also carries a global message-mode flag, which goes straight out to the switching core.

A host write to the mode register's address changes the steering from the next clock edge onward. Host accesses to addresses 0x20-0x3F then reach channel `addr[4:0]` of the chosen stream in the chosen memory. The block drives one read or write strobe per memory and a combined stream/channel address. It returns the selected memory's read data on the host bus.

In split mode, reads come from the data memory and writes go to the low connection memory, with no further mode-register write needed in between. The data memory can never be written from the host side.

Top module: `hpa_host_port`

## Requirements
- R1: After reset the mode register reads 0x00 and `msg_mode` is 0.
- R2: A host write with `host_addr` = 0x00 (the mode register offset) loads the register at that clock edge. `msg_mode` follows register bit 6 from the next cycle onward. No other access changes the register.
- R3: Register bit 5 always reads back as 0, whatever was written to it.
- R4: When register bit 7 (split) is 1, a channel read raises only `dm_rd`, and a channel write raises only `cml_wr`, whatever bits 4-3 hold.
- R5: When split is 0 and bits 4-3 = 01, a channel read raises `dm_rd`. A channel write raises no strobe at all, so the data memory cannot be written.
- R6: When split is 0, bits 4-3 = 10 steer channel reads and writes to `cml_rd`/`cml_wr`, and bits 4-3 = 11 steer them to `cmh_rd`/`cmh_wr`.
- R7: When split is 0 and bits 4-3 = 00, channel accesses raise no strobe and channel reads return 0x00.
- R8: `mem_addr` equals {register bits 2-0, `host_addr[4:0]`}, so the stream number sits above the channel number. A channel read returns the read data of the memory that was strobed.
- R9: An address with bit 5 = 0 other than the register offset raises no strobe, leaves the register unchanged and reads as 0x00.
- R10: A memory strobe is high only while the matching host strobe is high, and at most one memory strobe is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 6 | Host address; bit 5 selects the channel window |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_rdata | output | 8 | Host read data |
| dm_rdata | input | 8 | Read data from data memory |
| cml_rdata | input | 8 | Read data from low connection memory |
| cmh_rdata | input | 8 | Read data from high connection memory |
| dm_rd | output | 1 | Data memory read strobe |
| cml_rd | output | 1 | Low connection memory read strobe |
| cml_wr | output | 1 | Low connection memory write strobe |
| cmh_rd | output | 1 | High connection memory read strobe |
| cmh_wr | output | 1 | High connection memory write strobe |
| mem_addr | output | 8 | {stream, channel} memory address |
| mem_wdata | output | 8 | Write data to the memories |
| msg_mode | output | 1 | Global message-mode flag to the switching core |

## Verification
The assertions assume that `host_rd` and `host_wr` are never high in the same cycle. The one-strobe check relies on this, because a simultaneous read and write in split mode would raise two strobes legitimately. The stimulus picks each cycle's operation from read, write or idle, so the two strobes never overlap. The assertions also assume that inputs settle between clock edges. The bench drives every input just after the falling edge.

// File: rtl/hpa_pkg.sv
package hpa_pkg;
    // Memory choice field of the mode register (bits 4-3)
    typedef enum logic [1:0] {
        SEL_NONE = 2'b00,
        SEL_DM   = 2'b01,
        SEL_CML  = 2'b10,
        SEL_CMH  = 2'b11
    } mem_sel_e;

    localparam int STREAM_W = 3;

    // Mode register layout; bit positions are decoded by the steering logic
    typedef struct packed {
        logic                split;   // bit 7
        logic                msg;     // bit 6
        logic                spare;   // bit 5, held at 0
        mem_sel_e            sel;     // bits 4-3
        logic [STREAM_W-1:0] stream;  // bits 2-0
    } mode_t;

    typedef struct packed {
        logic dm_rd;
        logic cml_rd;
        logic cml_wr;
        logic cmh_rd;
        logic cmh_wr;
    } strobe_t;
endpackage

// File: rtl/hpa_mode_reg.sv
module hpa_mode_reg
    import hpa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [7:0] wdata,
    output mode_t      mode_q
);
    typedef struct packed {
        mode_t mode;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.mode       = mode_t'(wdata);
            st_d.mode.spare = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_q = st_q.mode;

    // The spare bit can never be stored
    assert_spare_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q.spare == 1'b0);
endmodule

// File: rtl/hpa_steer.sv
module hpa_steer
    import hpa_pkg::*;
#(
    parameter int CHAN_W   = 5,
    parameter int CTRL_OFS = 0,
    localparam int ADDR_W  = CHAN_W + 1,
    localparam int MADDR_W = STREAM_W + CHAN_W
)(
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic               host_rd,
    input  logic               host_wr,
    input  mode_t              mode,
    input  logic [7:0]         dm_rdata,
    input  logic [7:0]         cml_rdata,
    input  logic [7:0]         cmh_rdata,
    output strobe_t            strb,
    output logic               mode_load,
    output logic               mode_sel,
    output logic [7:0]         rdata,
    output logic [MADDR_W-1:0] mem_addr
);
    logic chan_hit;

    always_comb begin
        chan_hit  = host_addr[ADDR_W-1];
        mode_sel  = !chan_hit && (host_addr[CHAN_W-1:0] == CHAN_W'(CTRL_OFS));
        mode_load = mode_sel && host_wr;
        mem_addr  = {mode.stream, host_addr[CHAN_W-1:0]};
        strb      = '0;
        rdata     = 8'h00;

        if (chan_hit) begin
            if (mode.split) begin
                strb.dm_rd  = host_rd;
                strb.cml_wr = host_wr;
            end else begin
                unique case (mode.sel)
                    SEL_DM:  strb.dm_rd = host_rd;
                    SEL_CML: begin
                        strb.cml_rd = host_rd;
                        strb.cml_wr = host_wr;
                    end
                    SEL_CMH: begin
                        strb.cmh_rd = host_rd;
                        strb.cmh_wr = host_wr;
                    end
                    default: ;
                endcase
            end
        end

        if (strb.dm_rd)       rdata = dm_rdata;
        else if (strb.cml_rd) rdata = cml_rdata;
        else if (strb.cmh_rd) rdata = cmh_rdata;
        else if (mode_sel && host_rd) begin
            rdata    = mode;
            rdata[5] = 1'b0;
        end
    end
endmodule

// File: rtl/hpa_host_port.sv
module hpa_host_port
    import hpa_pkg::*;
#(
    parameter int CHAN_W   = 5,
    parameter int CTRL_OFS = 0,
    localparam int ADDR_W  = CHAN_W + 1,
    localparam int MADDR_W = STREAM_W + CHAN_W
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [7:0]         host_wdata,
    input  logic               host_rd,
    input  logic               host_wr,
    output logic [7:0]         host_rdata,
    input  logic [7:0]         dm_rdata,
    input  logic [7:0]         cml_rdata,
    input  logic [7:0]         cmh_rdata,
    output logic               dm_rd,
    output logic               cml_rd,
    output logic               cml_wr,
    output logic               cmh_rd,
    output logic               cmh_wr,
    output logic [MADDR_W-1:0] mem_addr,
    output logic [7:0]         mem_wdata,
    output logic               msg_mode
);
    mode_t   mode_q;
    strobe_t strb;
    logic    mode_load, mode_sel;

    hpa_mode_reg u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (mode_load),
        .wdata  (host_wdata),
        .mode_q (mode_q)
    );

    hpa_steer #(.CHAN_W(CHAN_W), .CTRL_OFS(CTRL_OFS)) u_steer (
        .host_addr (host_addr),
        .host_rd   (host_rd),
        .host_wr   (host_wr),
        .mode      (mode_q),
        .dm_rdata  (dm_rdata),
        .cml_rdata (cml_rdata),
        .cmh_rdata (cmh_rdata),
        .strb      (strb),
        .mode_load (mode_load),
        .mode_sel  (mode_sel),
        .rdata     (host_rdata),
        .mem_addr  (mem_addr)
    );

    assign dm_rd     = strb.dm_rd;
    assign cml_rd    = strb.cml_rd;
    assign cml_wr    = strb.cml_wr;
    assign cmh_rd    = strb.cmh_rd;
    assign cmh_wr    = strb.cmh_wr;
    assign mem_wdata = host_wdata;
    assign msg_mode  = mode_q.msg;

    // Assertions assume host_rd and host_wr are never high together
    assert_mode_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_load |=> $stable(mode_q));

    assert_readback_bit5_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && host_rd) |-> host_rdata[5] == 1'b0);

    assert_split_steer_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q.split && host_addr[ADDR_W-1] && host_rd) |-> (dm_rd && !cml_rd && !cmh_rd));

    assert_dm_readonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q.split && mode_q.sel == SEL_DM && host_wr) |-> !(cml_wr || cmh_wr));

    assert_sel_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q.split && mode_q.sel == SEL_NONE && host_addr[ADDR_W-1] && host_rd)
        |-> (strb == '0 && host_rdata == 8'h00));

    assert_one_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dm_rd, cml_rd, cml_wr, cmh_rd, cmh_wr}));

    assert_strobe_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_rd |-> !(dm_rd || cml_rd || cmh_rd)) and (!host_wr |-> !(cml_wr || cmh_wr)));
endmodule

// File: tb/hpa_host_port_test.sv
module hpa_host_port_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_rd = 1'b0, host_wr = 1'b0;
    logic [7:0] host_rdata;
    logic [7:0] dm_rdata = 8'h11, cml_rdata = 8'h22, cmh_rdata = 8'h33;
    logic       dm_rd, cml_rd, cml_wr, cmh_rd, cmh_wr, msg_mode;
    logic [7:0] mem_addr, mem_wdata;

    int checks = 0, errors = 0;
    logic [7:0] model = 8'h00;   // bench copy of the mode register

    always #10 clk = ~clk;       // 50 MHz

    hpa_host_port uut (.*);

    // Expected strobes as {dm_rd, cml_rd, cml_wr, cmh_rd, cmh_wr}
    function automatic logic [4:0] exp_strb(logic [7:0] m, logic [5:0] a, logic r, logic w);
        if (!a[5]) return 5'b0;                       // R9
        if (m[7]) return {r, 1'b0, w, 2'b00};         // R4
        case (m[4:3])
            2'b01:   return {r, 4'b0};                // R5
            2'b10:   return {1'b0, r, w, 2'b00};      // R6
            2'b11:   return {3'b0, r, w};             // R6
            default: return 5'b0;                     // R7
        endcase
    endfunction

    function automatic logic [7:0] exp_rdata(logic [7:0] m, logic [5:0] a, logic r);
        logic [4:0] s;
        if (!r) return 8'h00;
        if (a == 6'h00) return m & 8'hDF;             // R3
        s = exp_strb(m, a, 1'b1, 1'b0);
        if (s[4]) return dm_rdata;                    // R8
        if (s[3]) return cml_rdata;
        if (s[1]) return cmh_rdata;
        return 8'h00;
    endfunction

    function automatic string tag_of(logic [7:0] m, logic [5:0] a);
        if (a == 6'h00) return "R2/R3";
        if (!a[5]) return "R9";
        if (m[7]) return "R4";
        case (m[4:3])
            2'b01: return "R5";
            2'b00: return "R7";
            default: return "R6";
        endcase
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic access(logic [5:0] a, logic [7:0] d, logic r, logic w);
        @(negedge clk);
        host_addr = a; host_wdata = d; host_rd = r; host_wr = w;
        dm_rdata = 8'($urandom); cml_rdata = 8'($urandom); cmh_rdata = 8'($urandom);
        #5;
        check({tag_of(model, a), " strobes R10"},
              {27'b0, dm_rd, cml_rd, cml_wr, cmh_rd, cmh_wr}, {27'b0, exp_strb(model, a, r, w)});
        if (r) check({tag_of(model, a), " rdata"}, {24'b0, host_rdata}, {24'b0, exp_rdata(model, a, r)});
        if (a[5]) check("R8 mem_addr", {24'b0, mem_addr}, {24'b0, model[2:0], a[4:0]});
        check("R2 msg_mode", {31'b0, msg_mode}, {31'b0, model[6]});
        @(posedge clk);
        #1;
        if (w && a == 6'h00) model = d;
        host_rd = 1'b0; host_wr = 1'b0;
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state
        access(6'h00, 8'h00, 1'b1, 1'b0);
        check("R1 reset msg_mode", {31'b0, msg_mode}, 32'd0);
        // R3: spare bit never reads back
        access(6'h00, 8'hFF, 1'b0, 1'b1);
        access(6'h00, 8'h00, 1'b1, 1'b0);
        // R4: split mode with each memory choice
        for (int s = 0; s < 4; s++) begin
            access(6'h00, 8'h80 | 8'(s << 3) | 8'h05, 1'b0, 1'b1);
            access(6'h3F, 8'hA5, 1'b0, 1'b1);
            access(6'h21, 8'h00, 1'b1, 1'b0);
        end
        // R5/R6/R7 directed with each choice, boundary channels
        for (int s = 0; s < 4; s++) begin
            access(6'h00, 8'(s << 3) | 8'h47, 1'b0, 1'b1);
            access(6'h20, 8'h5A, 1'b0, 1'b1);
            access(6'h3F, 8'h00, 1'b1, 1'b0);
        end
        // R9: non-register low addresses
        access(6'h1F, 8'hFF, 1'b0, 1'b1);
        access(6'h01, 8'h00, 1'b1, 1'b0);
        access(6'h00, 8'h00, 1'b1, 1'b0);
        // Random mix
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 9);
            logic [5:0] a = ($urandom_range(0, 4) == 0) ? 6'($urandom_range(0, 31)) : 6'h20 | 6'($urandom);
            if (op == 0) access(6'h00, 8'($urandom), 1'b0, 1'b1);
            else if (op < 5) access(a, 8'($urandom), 1'b1, 1'b0);
            else if (op < 9) access(a, 8'($urandom), 1'b0, 1'b1);
            else access(a, 8'($urandom), 1'b0, 1'b0);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule